// File: doc/BRIEF.md
# Shared-Bus Frame Address Snooper

This block sits beside a switch's shared packet-memory write bus and only listens. Every cycle one port owns the bus, and the word it writes carries a direction code and a word-status code. The snooper keeps the words that belong to received frames and rebuilds the destination and source MAC addresses of each frame. It then emits a one-cycle report that holds both addresses, the port that sent the frame, and a flag showing whether an error status arrived for that frame before the report went out. The block holds partial state for each port, so frames from different ports can interleave word by word on the bus.

The data bus is 48 or 64 bits wide, set by a parameter. With a 48-bit bus, the first tagged word of a frame is the destination address and the second is the source address. With a 64-bit bus, the destination address is the upper 48 bits of the first word. The source address is the lower 16 bits of the first word followed by the upper 32 bits of the second word. A parameter also sets how the owning port is identified. One option is an explicit 5-bit port number. The other is a slot counter that a sync pulse resets to port 0 and that advances by one every clock.

Top module: `frame_addr_snooper`

## Requirements
- R1: The block ignores a word unless its direction code is 2'b01 (receive). Codes 2'b00, 2'b10 and 2'b11 cause no report and change no stored state: no partial address, no error flag and no frame-boundary tracking.
- R2: In 48-bit mode, a receive word with status 4'b0001 supplies the destination address. A later receive word on the same port with status 4'b0010 supplies the source address. One clock after that second word is sampled, `rpt_valid` is high for exactly one cycle, with both addresses and the port number.
- R3: In 64-bit mode, the reported destination address is bits [63:16] of the first word. The reported source address is {first word bits [15:0], second word bits [63:32]}.
- R4: Each port keeps its own partial address. When first and second words of several ports interleave on the bus, each report carries only that port's own words.
- R5: A status 4'b0010 word produces a report only if the same port captured a 4'b0001 word earlier and has not reported since. A second 4'b0010 word with no new first word produces nothing.
- R6: A receive word whose status is in the range 4'b0101 to 4'b1110 sets an error mark for its port. The next report from that port has `rpt_err` high, and the report clears the mark. Status codes 4'b0000, 4'b0011, 4'b0100 and 4'b1111 never set the mark.
- R7: `eof_lvl` is high while a port is idle, and it is tracked separately for each port on receive words. A high-to-low change marks a frame start and clears the port's error mark and any captured first word. A low-to-high change marks a frame end and discards any captured first word that has not been reported.
- R8: In explicit mode (USE_SYNC=0), the owning port is `port_id_in` and `sync_pulse` has no effect. A word whose `port_id_in` is NUM_PORTS or higher is ignored.
- R9: In slot mode (USE_SYNC=1), `port_id_in` has no effect. A cycle with `sync_pulse` high belongs to port 0. Each following cycle belongs to the next port number, and the count wraps from NUM_PORTS-1 back to 0.
- R10: While reset is held and after it is released, `rpt_valid` stays low until a complete first/second word pair has been seen. Every port starts out idle, with no captured word and no error mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; the block samples on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_data | input | BUS_W | Word currently being written on the shared bus |
| word_stat | input | 4 | Status code tagging the current word |
| dir_code | input | 2 | Direction code; 2'b01 is receive |
| eof_lvl | input | 1 | Frame-boundary level of the owning port; high when idle |
| sync_pulse | input | 1 | Marks the port-0 slot in slot mode |
| port_id_in | input | 5 | Owning port number in explicit mode |
| rpt_valid | output | 1 | One-cycle report strobe |
| rpt_da | output | 48 | Reported destination address |
| rpt_sa | output | 48 | Reported source address |
| rpt_port | output | 5 | Port the report belongs to |
| rpt_err | output | 1 | An error status was seen for this frame before the report |

## Verification
The assertions assume that a report can only follow a receive word tagged 4'b0010. They also assume that one port never reports in two back-to-back cycles, and that in slot mode the counter holds the value 1 in the cycle after a sync pulse. The stimulus holds every input steady between falling edges. It drives a single owner per cycle and raises the sync pulse only in slot-mode phases. It also gates the direction code, so that at any time only one of the three instances under test sees receive traffic.

// File: rtl/snoop_pkg.sv
package snoop_pkg;
    localparam int ADDR_W = 48;
    localparam int PID_W  = 5;

    localparam logic [1:0] DIR_RX    = 2'b01;
    localparam logic [3:0] ST_FIRST  = 4'b0001;
    localparam logic [3:0] ST_SECOND = 4'b0010;
    localparam logic [3:0] ST_ERR_LO = 4'b0101;
    localparam logic [3:0] ST_ERR_HI = 4'b1110;

    function automatic logic stat_is_error(input logic [3:0] s);
        return (s >= ST_ERR_LO) && (s <= ST_ERR_HI);
    endfunction
endpackage

// File: rtl/snoop_word_decode.sv
module snoop_word_decode
    import snoop_pkg::*;
(
    input  logic [1:0] dir_code,
    input  logic [3:0] word_stat,
    output logic       rx_ok,
    output logic       is_first,
    output logic       is_second,
    output logic       is_error
);
    always_comb begin
        rx_ok     = (dir_code == DIR_RX);
        is_first  = rx_ok && (word_stat == ST_FIRST);
        is_second = rx_ok && (word_stat == ST_SECOND);
        is_error  = rx_ok && stat_is_error(word_stat);
    end
endmodule

// File: rtl/snoop_port_sel.sv
module snoop_port_sel
    import snoop_pkg::*;
#(
    parameter int NUM_PORTS = 8,
    parameter bit USE_SYNC  = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_pulse,
    input  logic [PID_W-1:0] port_id_in,
    output logic [PID_W-1:0] cur_port,
    output logic             port_ok
);
    localparam logic [PID_W-1:0] LAST_PORT  = PID_W'(NUM_PORTS - 1);
    localparam logic [PID_W-1:0] AFTER_SYNC = (NUM_PORTS > 1) ? PID_W'(1) : PID_W'(0);

    logic [PID_W-1:0] slot_d, slot_q;
    logic [PID_W-1:0] slot_now;

    always_comb begin
        slot_now = sync_pulse ? '0 : slot_q;
        slot_d   = (slot_now == LAST_PORT) ? '0 : slot_now + PID_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    generate
        if (USE_SYNC) begin : g_slot
            logic unused_pid;
            assign unused_pid = ^port_id_in;
            assign cur_port   = slot_now;
            assign port_ok    = 1'b1;

            a_r9_slot_after_sync: assert property (@(posedge clk) disable iff (!rst_n)
                sync_pulse |=> (slot_q == AFTER_SYNC));
        end else begin : g_explicit
            assign cur_port = port_id_in;
            assign port_ok  = ({27'b0, port_id_in} < NUM_PORTS);
        end
    endgenerate

    a_r9_slot_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        ({27'b0, slot_q} < NUM_PORTS));
endmodule

// File: rtl/snoop_port_state.sv
module snoop_port_state
    import snoop_pkg::*;
#(
    parameter int BUS_W     = 48,
    parameter int NUM_PORTS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_W-1:0]  word,
    input  logic              eof_lvl,
    input  logic              rx_ok,
    input  logic              is_first,
    input  logic              is_second,
    input  logic              is_error,
    input  logic [PID_W-1:0]  cur_port,
    input  logic              port_ok,
    output logic              rpt_valid,
    output logic [ADDR_W-1:0] rpt_da,
    output logic [ADDR_W-1:0] rpt_sa,
    output logic [PID_W-1:0]  rpt_port,
    output logic              rpt_err
);
    localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

    typedef struct packed {
        logic [NUM_PORTS-1:0][BUS_W-1:0] part;
        logic [NUM_PORTS-1:0]            have_first;
        logic [NUM_PORTS-1:0]            err_mark;
        logic [NUM_PORTS-1:0]            eof_prev;
        logic                            valid;
        logic [ADDR_W-1:0]               da;
        logic [ADDR_W-1:0]               sa;
        logic [PID_W-1:0]                port;
        logic                            err;
    } state_t;

    state_t st_d, st_q;

    logic [IDX_W-1:0]  idx;
    logic [BUS_W-1:0]  part_sel;
    logic [ADDR_W-1:0] da_w, sa_w;

    assign idx      = cur_port[IDX_W-1:0];
    assign part_sel = st_q.part[idx];

    generate
        if (BUS_W == 64) begin : g_w64
            assign da_w = part_sel[63:16];
            assign sa_w = {part_sel[15:0], word[63:32]};
        end else begin : g_w48
            assign da_w = part_sel[47:0];
            assign sa_w = word[47:0];
        end
    endgenerate

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (rx_ok && port_ok) begin
            if (st_q.eof_prev[idx] && !eof_lvl) begin
                st_d.have_first[idx] = 1'b0;
                st_d.err_mark[idx]   = 1'b0;
            end
            if (!st_q.eof_prev[idx] && eof_lvl) begin
                st_d.have_first[idx] = 1'b0;
            end
            st_d.eof_prev[idx] = eof_lvl;
            if (is_error) begin
                st_d.err_mark[idx] = 1'b1;
            end
            if (is_first) begin
                st_d.part[idx]       = word;
                st_d.have_first[idx] = 1'b1;
            end else if (is_second && st_d.have_first[idx]) begin
                st_d.valid           = 1'b1;
                st_d.da              = da_w;
                st_d.sa              = sa_w;
                st_d.port            = cur_port;
                st_d.err             = st_d.err_mark[idx];
                st_d.have_first[idx] = 1'b0;
                st_d.err_mark[idx]   = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.eof_prev <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rpt_valid = st_q.valid;
    assign rpt_da    = st_q.da;
    assign rpt_sa    = st_q.sa;
    assign rpt_port  = st_q.port;
    assign rpt_err   = st_q.err;

    generate
        if (BUS_W == 64) begin : g_chk64
            a_r3_sa_tail_from_second: assert property (@(posedge clk) disable iff (!rst_n)
                st_q.valid |-> (st_q.sa[31:0] == $past(word[63:32])));
        end else begin : g_chk48
            a_r2_sa_from_second: assert property (@(posedge clk) disable iff (!rst_n)
                st_q.valid |-> (st_q.sa == $past(word[47:0])));
        end
    endgenerate
endmodule

// File: rtl/frame_addr_snooper.sv
module frame_addr_snooper
    import snoop_pkg::*;
#(
    parameter int BUS_W     = 48,
    parameter int NUM_PORTS = 8,
    parameter bit USE_SYNC  = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_W-1:0]  bus_data,
    input  logic [3:0]        word_stat,
    input  logic [1:0]        dir_code,
    input  logic              eof_lvl,
    input  logic              sync_pulse,
    input  logic [PID_W-1:0]  port_id_in,
    output logic              rpt_valid,
    output logic [ADDR_W-1:0] rpt_da,
    output logic [ADDR_W-1:0] rpt_sa,
    output logic [PID_W-1:0]  rpt_port,
    output logic              rpt_err
);
    logic             rx_ok, is_first, is_second, is_error;
    logic [PID_W-1:0] cur_port;
    logic             port_ok;

    snoop_word_decode i_decode (
        .dir_code  (dir_code),
        .word_stat (word_stat),
        .rx_ok     (rx_ok),
        .is_first  (is_first),
        .is_second (is_second),
        .is_error  (is_error)
    );

    snoop_port_sel #(
        .NUM_PORTS (NUM_PORTS),
        .USE_SYNC  (USE_SYNC)
    ) i_port_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_pulse (sync_pulse),
        .port_id_in (port_id_in),
        .cur_port   (cur_port),
        .port_ok    (port_ok)
    );

    snoop_port_state #(
        .BUS_W     (BUS_W),
        .NUM_PORTS (NUM_PORTS)
    ) i_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .word      (bus_data),
        .eof_lvl   (eof_lvl),
        .rx_ok     (rx_ok),
        .is_first  (is_first),
        .is_second (is_second),
        .is_error  (is_error),
        .cur_port  (cur_port),
        .port_ok   (port_ok),
        .rpt_valid (rpt_valid),
        .rpt_da    (rpt_da),
        .rpt_sa    (rpt_sa),
        .rpt_port  (rpt_port),
        .rpt_err   (rpt_err)
    );

    a_r1_report_needs_rx_second: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_valid |-> $past(dir_code == DIR_RX && word_stat == ST_SECOND));

    a_r5_no_back_to_back_same_port: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_valid && $past(rpt_valid)) |-> (rpt_port != $past(rpt_port)));

    a_r8_port_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_valid |-> ({27'b0, rpt_port} < NUM_PORTS));

    generate
        if (USE_SYNC) begin : g_chk_slot
            a_r9_sync_slot_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
                (rpt_valid && $past(sync_pulse)) |-> (rpt_port == '0));
        end else begin : g_chk_explicit
            a_r8_port_from_id: assert property (@(posedge clk) disable iff (!rst_n)
                rpt_valid |-> (rpt_port == $past(port_id_in)));
        end
    endgenerate
endmodule

// File: tb/test_frame_addr_snooper.sv
`timescale 1ns/1ps
module test_frame_addr_snooper;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] data64 = '0;
    logic [3:0]  stat = '0;
    logic [1:0]  dir = '0;
    logic        eof = 1'b1;
    logic        sync = 1'b0;
    logic [4:0]  pid = '0;
    int          tgt = 0;
    bit          done = 0;

    always #2.5 clk = ~clk;

    logic [1:0] dir_a, dir_b, dir_c;
    assign dir_a = (tgt == 0) ? dir : 2'b00;
    assign dir_b = (tgt == 1) ? dir : 2'b00;
    assign dir_c = (tgt == 2) ? dir : 2'b00;

    logic        va, vb, vc, ea, eb, ec;
    logic [47:0] daa, saa, dab, sab, dac, sac;
    logic [4:0]  pa, pb, pc;

    frame_addr_snooper #(.BUS_W(48), .NUM_PORTS(8), .USE_SYNC(1'b0)) i_frame_addr_snooper (
        .clk(clk), .rst_n(rst_n), .bus_data(data64[47:0]), .word_stat(stat), .dir_code(dir_a),
        .eof_lvl(eof), .sync_pulse(sync), .port_id_in(pid),
        .rpt_valid(va), .rpt_da(daa), .rpt_sa(saa), .rpt_port(pa), .rpt_err(ea));

    frame_addr_snooper #(.BUS_W(64), .NUM_PORTS(8), .USE_SYNC(1'b0)) i_frame_addr_snooper_w64 (
        .clk(clk), .rst_n(rst_n), .bus_data(data64), .word_stat(stat), .dir_code(dir_b),
        .eof_lvl(eof), .sync_pulse(sync), .port_id_in(pid),
        .rpt_valid(vb), .rpt_da(dab), .rpt_sa(sab), .rpt_port(pb), .rpt_err(eb));

    frame_addr_snooper #(.BUS_W(48), .NUM_PORTS(4), .USE_SYNC(1'b1)) i_frame_addr_snooper_sync (
        .clk(clk), .rst_n(rst_n), .bus_data(data64[47:0]), .word_stat(stat), .dir_code(dir_c),
        .eof_lvl(eof), .sync_pulse(sync), .port_id_in(pid),
        .rpt_valid(vc), .rpt_da(dac), .rpt_sa(sac), .rpt_port(pc), .rpt_err(ec));

    typedef struct {
        logic [47:0] da;
        logic [47:0] sa;
        logic [4:0]  port;
        logic        err;
        string       tag;
    } exp_t;

    exp_t qa[$], qb[$], qc[$];
    int   pushed[3];
    int   seen[3];
    int   total = 0;
    int   bad = 0;

    task automatic push(input int i, input logic [47:0] da, input logic [47:0] sa,
                        input logic [4:0] p, input logic e, input string tag);
        exp_t x;
        x.da = da; x.sa = sa; x.port = p; x.err = e; x.tag = tag;
        pushed[i]++;
        case (i)
            0: qa.push_back(x);
            1: qb.push_back(x);
            default: qc.push_back(x);
        endcase
    endtask

    task automatic take(input int i, input logic [47:0] da, input logic [47:0] sa,
                        input logic [4:0] p, input logic e);
        exp_t x;
        bit   have = 0;
        seen[i]++;
        total++;
        case (i)
            0: if (qa.size() > 0) begin x = qa.pop_front(); have = 1; end
            1: if (qb.size() > 0) begin x = qb.pop_front(); have = 1; end
            default: if (qc.size() > 0) begin x = qc.pop_front(); have = 1; end
        endcase
        if (!have) begin
            bad++;
            $display("FAIL R5 inst%0d unexpected report actual da=%h sa=%h port=%0d expected none",
                     i, da, sa, p);
        end else if (x.da !== da || x.sa !== sa || x.port !== p || x.err !== e) begin
            bad++;
            $display("FAIL %s inst%0d actual da=%h sa=%h port=%0d err=%b expected da=%h sa=%h port=%0d err=%b",
                     x.tag, i, da, sa, p, e, x.da, x.sa, x.port, x.err);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (va) take(0, daa, saa, pa, ea);
            if (vb) take(1, dab, sab, pb, eb);
            if (vc) take(2, dac, sac, pc, ec);
        end
    end

    function automatic logic [63:0] w48(input logic [47:0] v);
        return {16'h0000, v};
    endfunction

    task automatic word(input logic [4:0] p, input logic sy, input logic [1:0] d,
                        input logic [3:0] s, input logic e, input logic [63:0] w);
        @(negedge clk);
        pid = p; sync = sy; dir = d; stat = s; eof = e; data64 = w;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            dir = 2'b00; sync = 1'b0; stat = 4'b0000;
        end
    endtask

    task automatic quiet(input int i, input string tag);
        idle(3);
        #1;
        total++;
        if (seen[i] != pushed[i]) begin
            bad++;
            $display("FAIL %s inst%0d report count actual=%0d expected=%0d", tag, i, seen[i], pushed[i]);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R10: outputs quiet during reset
        total++;
        if (va || vb || vc) begin
            bad++;
            $display("FAIL R10 strobe in reset actual=%b%b%b expected=000", va, vb, vc);
        end
        rst_n = 1'b1;
        quiet(0, "R10");

        // ---- instance A: 48-bit explicit ----
        tgt = 0;
        // R2: basic first/second
        word(3, 0, 2'b01, 4'b0001, 0, w48(48'h0011_2233_4455));
        word(3, 0, 2'b01, 4'b0010, 0, w48(48'h6677_8899_AABB));
        push(0, 48'h0011_2233_4455, 48'h6677_8899_AABB, 3, 0, "R2");
        word(3, 0, 2'b01, 4'b0000, 1, w48(48'h0));
        quiet(0, "R2");

        // R1: non-receive words are ignored
        word(2, 0, 2'b01, 4'b0001, 0, w48(48'hA1A1_A1A1_A1A1));
        word(2, 0, 2'b10, 4'b0001, 0, w48(48'hBADB_ADBA_DBAD));
        word(2, 0, 2'b11, 4'b0010, 0, w48(48'hBADB_ADBA_DBAD));
        word(2, 0, 2'b00, 4'b1101, 1, w48(48'hBADB_ADBA_DBAD));
        quiet(0, "R1");
        word(2, 0, 2'b01, 4'b0010, 0, w48(48'hC2C2_C2C2_C2C2));
        push(0, 48'hA1A1_A1A1_A1A1, 48'hC2C2_C2C2_C2C2, 2, 0, "R1");
        word(2, 0, 2'b01, 4'b0000, 1, w48(48'h0));
        quiet(0, "R1");

        // R5: second without first, and repeated second
        word(5, 0, 2'b01, 4'b0010, 0, w48(48'h5555_0000_0001));
        quiet(0, "R5");
        word(5, 0, 2'b01, 4'b0001, 0, w48(48'h5555_0000_0002));
        word(5, 0, 2'b01, 4'b0010, 0, w48(48'h5555_0000_0003));
        push(0, 48'h5555_0000_0002, 48'h5555_0000_0003, 5, 0, "R5");
        word(5, 0, 2'b01, 4'b0010, 0, w48(48'h5555_0000_0004));
        word(5, 0, 2'b01, 4'b0000, 1, w48(48'h0));
        quiet(0, "R5");

        // R4: interleaved ports
        word(1, 0, 2'b01, 4'b0001, 0, w48(48'h1111_1111_1111));
        word(6, 0, 2'b01, 4'b0001, 0, w48(48'h6666_6666_6666));
        word(1, 0, 2'b01, 4'b0010, 0, w48(48'h1111_2222_3333));
        push(0, 48'h1111_1111_1111, 48'h1111_2222_3333, 1, 0, "R4");
        word(6, 0, 2'b01, 4'b0010, 0, w48(48'h6666_7777_8888));
        push(0, 48'h6666_6666_6666, 48'h6666_7777_8888, 6, 0, "R4");
        word(1, 0, 2'b01, 4'b0000, 1, w48(48'h0));
        word(6, 0, 2'b01, 4'b0000, 1, w48(48'h0));
        quiet(0, "R4");

        // R6: error codes at both ends of the range, reserved codes harmless
        word(4, 0, 2'b01, 4'b0001, 0, w48(48'h4444_0000_0001));
        word(4, 0, 2'b01, 4'b1101, 0, w48(48'h0));
        word(4, 0, 2'b01, 4'b0010, 0, w48(48'h4444_0000_0002));
        push(0, 48'h4444_0000_0001, 48'h4444_0000_0002, 4, 1, "R6");
        word(4, 0, 2'b01, 4'b0000, 1, w48(48'h0));
        word(4, 0, 2'b01, 4'b0001, 0, w48(48'h4444_0000_0003));
        word(4, 0, 2'b01, 4'b0011, 0, w48(48'h0));
        word(4, 0, 2'b01, 4'b0100, 0, w48(48'h0));
        word(4, 0, 2'b01, 4'b1111, 0, w48(48'h0));
        word(4, 0, 2'b01, 4'b0000, 0, w48(48'h0));
        word(4, 0, 2'b01, 4'b0010, 0, w48(48'h4444_0000_0004));
        push(0, 48'h4444_0000_0003, 48'h4444_0000_0004, 4, 0, "R6");
        word(4, 0, 2'b01, 4'b0000, 1, w48(48'h0));
        word(4, 0, 2'b01, 4'b0001, 0, w48(48'h4444_0000_0005));
        word(4, 0, 2'b01, 4'b0101, 0, w48(48'h0));
        word(4, 0, 2'b01, 4'b0010, 0, w48(48'h4444_0000_0006));
        push(0, 48'h4444_0000_0005, 48'h4444_0000_0006, 4, 1, "R6");
        word(4, 0, 2'b01, 4'b1110, 1, w48(48'h0));
        quiet(0, "R6");

        // R7: frame start clears an idle-time error; frame end drops a pending first word
        word(7, 0, 2'b01, 4'b1000, 1, w48(48'h0));
        word(7, 0, 2'b01, 4'b0001, 0, w48(48'h7777_0000_0001));
        word(7, 0, 2'b01, 4'b0010, 0, w48(48'h7777_0000_0002));
        push(0, 48'h7777_0000_0001, 48'h7777_0000_0002, 7, 0, "R7");
        word(7, 0, 2'b01, 4'b0000, 1, w48(48'h0));
        word(7, 0, 2'b01, 4'b0001, 0, w48(48'h7777_0000_0003));
        word(7, 0, 2'b01, 4'b0000, 1, w48(48'h0));
        word(7, 0, 2'b01, 4'b0010, 1, w48(48'h7777_0000_0004));
        quiet(0, "R7");

        // R8: port numbers at or above NUM_PORTS are ignored
        word(8, 0, 2'b01, 4'b0001, 0, w48(48'h8888_0000_0001));
        word(8, 0, 2'b01, 4'b0010, 0, w48(48'h8888_0000_0002));
        word(9, 0, 2'b01, 4'b0001, 0, w48(48'h9999_0000_0001));
        word(9, 1, 2'b01, 4'b0010, 0, w48(48'h9999_0000_0002));
        quiet(0, "R8");
        word(0, 1, 2'b01, 4'b0001, 0, w48(48'h0000_0000_0A0A));
        word(0, 0, 2'b01, 4'b0010, 0, w48(48'h0000_0000_0B0B));
        push(0, 48'h0000_0000_0A0A, 48'h0000_0000_0B0B, 0, 0, "R8");
        word(0, 0, 2'b01, 4'b0000, 1, w48(48'h0));
        quiet(0, "R8");

        // ---- instance B: 64-bit explicit ----
        tgt = 1;
        word(2, 0, 2'b01, 4'b0001, 0, 64'hAAAA_BBBB_CCCC_1234);
        word(2, 0, 2'b01, 4'b0010, 0, 64'h5678_9ABC_DEAD_BEEF);
        push(1, 48'hAAAA_BBBB_CCCC, 48'h1234_5678_9ABC, 2, 0, "R3");
        word(2, 0, 2'b01, 4'b0000, 1, 64'h0);
        word(0, 0, 2'b01, 4'b0001, 0, 64'h0101_0202_0303_0A0A);
        word(1, 0, 2'b01, 4'b0001, 0, 64'h1010_2020_3030_0B0B);
        word(0, 0, 2'b01, 4'b0010, 0, 64'hC0C0_C0C0_FFFF_FFFF);
        push(1, 48'h0101_0202_0303, 48'h0A0A_C0C0_C0C0, 0, 0, "R3");
        word(1, 0, 2'b01, 4'b0010, 0, 64'hD0D0_D0D0_0000_0000);
        push(1, 48'h1010_2020_3030, 48'h0B0B_D0D0_D0D0, 1, 0, "R4");
        quiet(1, "R3");

        // ---- instance C: 48-bit slot mode, 4 ports ----
        tgt = 2;
        word(3, 1, 2'b01, 4'b0001, 0, w48(48'hC000_0000_0000));
        word(3, 0, 2'b01, 4'b0001, 0, w48(48'hC111_0000_0000));
        word(3, 0, 2'b00, 4'b0000, 0, w48(48'h0));
        word(3, 0, 2'b00, 4'b0000, 0, w48(48'h0));
        word(3, 0, 2'b01, 4'b0010, 0, w48(48'h5000_0000_0000));
        push(2, 48'hC000_0000_0000, 48'h5000_0000_0000, 0, 0, "R9");
        word(3, 0, 2'b01, 4'b0010, 0, w48(48'h5111_0000_0000));
        push(2, 48'hC111_0000_0000, 48'h5111_0000_0000, 1, 0, "R9");
        quiet(2, "R9");

        // final: nothing left over on any instance
        for (int i = 0; i < 3; i++) begin
            total++;
            if (seen[i] != pushed[i]) begin
                bad++;
                $display("FAIL R5 inst%0d final count actual=%0d expected=%0d", i, seen[i], pushed[i]);
            end
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule